// File: doc/BRIEF.md
# High-Speed Host Chirp Sequencer

This block is the link-side controller of a downstream-facing USB port during a bus reset. It runs the host half of the high-speed detection handshake. When asked to reset the bus, it drives SE0 and watches the PHY's line state for a device Chirp K. A Chirp K counts only when it has lasted long enough. Once a counted Chirp K ends, the block waits a fixed gap. It then issues a NOPID transmit command that carries an alternating train of Chirp K and Chirp J, and finally sets the PHY operating mode back to normal so that high-speed packets can follow. If no device chirp is counted before the reset interval runs out, the port finishes in full-speed mode and sends no train.

All timing uses a clock-enable `tick`. The parameter `TICKS_PER_US` states how many ticks make one microsecond. Lengths are given in microseconds and turned into tick counts at elaboration. The line state passes through a configurable synchronizer before it is examined.

Top module: `hcs_host_chirp_seq`

## Requirements
- R1: After reset, and until a bus reset is requested, `opmode` is 01 (non-driving), and `se0_drive`, `txcmd_nopid` and `handshake_done` are all 0.
- R2: A one-cycle `bus_reset_req` starts a bus reset. While the reset runs, `se0_drive` is 1 and `opmode` is 10.
- R3: A device Chirp K is linestate 10. It is accepted only after it has been seen on ceil(2.5 × TICKS_PER_US) consecutive ticks, which is 5 ticks at 2 ticks per µs. A run of 4 ticks is ignored.
- R4: After an accepted Chirp K leaves the K state, `txcmd_nopid` rises after GAP_US µs plus the synchronizer delay. This is never more than 100 µs.
- R5: The host train holds `txcmd_nopid` at 1 and makes 2 × PAIRS chirps. The first chirp is K and the levels alternate after that. `chirp_j` is 0 for K and 1 for J.
- R6: Each host chirp lasts exactly CHIRP_US × TICKS_PER_US ticks. CHIRP_US is limited to 40..60.
- R7: After the train, `opmode` is 00, `se0_drive` is 0, `hs_mode` is 1 and `handshake_done` is 1.
- R8: If no chirp is accepted, `se0_drive` stays 1 for exactly RESET_US × TICKS_PER_US ticks. The block then ends with `opmode` 00, `hs_mode` 0 and `handshake_done` 1, and no transmit command is sent.
- R9: Once a chirp has been accepted, the line state is ignored. Further K on the line during the gap or the train does not change the train.
- R10: Timers and the K run counter advance only on cycles with `tick` high, so with a tick every other cycle each duration takes twice as many clock cycles.
- R11: A `bus_reset_req` given after the handshake has finished starts a new bus reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Time-base clock enable |
| bus_reset_req | input | 1 | Pulse that starts a bus reset |
| linestate | input | 2 | PHY line state (00 SE0, 01 J, 10 K) |
| opmode | output | 2 | PHY operating mode |
| se0_drive | output | 1 | Host drives SE0 |
| txcmd_nopid | output | 1 | NOPID transmit command active (chirp train) |
| chirp_j | output | 1 | Current chirp level: 0 K, 1 J |
| hs_mode | output | 1 | Port finished in high-speed mode |
| handshake_done | output | 1 | Handshake finished (high- or full-speed) |

## Verification
The bench aims at the acceptance threshold for the device K, using a run one tick too short and a run of exactly the minimum. A design with an off-by-one would either start a train on noise or fall back to full speed when it should not. A scoreboard compares the level and cycle length of every host chirp, so a train that starts with J, toggles early or has one chirp too many or too few is caught, and it runs under two tick rates to expose timers that count clock cycles instead of ticks. A full-speed run counts the exact number of SE0 cycles. Stray K driven during the gap checks that the line state is ignored after acceptance, and a second reset request issued from the finished state checks that the sequence restarts.

// File: rtl/hcs_pkg.sv
package hcs_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RESET,
      ST_GAP,
      ST_CHIRP,
      ST_HS,
      ST_FS
   } seq_state_t;

   localparam logic [1:0] LS_SE0 = 2'b00;
   localparam logic [1:0] LS_J   = 2'b01;
   localparam logic [1:0] LS_K   = 2'b10;

   localparam logic [1:0] OPM_NORMAL  = 2'b00;
   localparam logic [1:0] OPM_NODRIVE = 2'b01;
   localparam logic [1:0] OPM_RAW     = 2'b10;
endpackage

// File: rtl/hcs_tick_timer.sv
module hcs_tick_timer #(
   parameter int LIMIT = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic tick,
   output logic expire
);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("hcs_tick_timer: LIMIT must be at least 1");
   end

   logic [CW-1:0] cnt;

   assign expire = run && tick && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run || expire) begin
         cnt <= '0;
      end else if (tick) begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/hcs_kchirp_qual.sv
module hcs_kchirp_qual
   import hcs_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int MIN_TICKS   = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       arm,
   input  logic       tick,
   input  logic [1:0] linestate,
   output logic       qualified,
   output logic       chirp_ended
);
   localparam int RW = $clog2(MIN_TICKS + 1);
   localparam logic [RW-1:0] RUN_LAST = RW'(MIN_TICKS - 1);

   if (MIN_TICKS < 1) begin : g_bad_min
      $error("hcs_kchirp_qual: MIN_TICKS must be at least 1");
   end

   logic [1:0] ls_s;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign ls_s = linestate;
   end else begin : g_sync
      logic [1:0] stage [SYNC_STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) stage[i] <= LS_SE0;
         end else begin
            stage[0] <= linestate;
            for (int i = 1; i < SYNC_STAGES; i++) stage[i] <= stage[i-1];
         end
      end
      assign ls_s = stage[SYNC_STAGES-1];
   end

   logic          ls_is_k;
   logic [RW-1:0] run_cnt;
   logic          reach;

   assign ls_is_k     = (ls_s == LS_K);
   assign reach       = arm && ls_is_k && tick && (run_cnt == RUN_LAST);
   assign chirp_ended = qualified && !ls_is_k;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt   <= '0;
         qualified <= 1'b0;
      end else if (!arm) begin
         run_cnt   <= '0;
         qualified <= 1'b0;
      end else begin
         if (!ls_is_k)                          run_cnt <= '0;
         else if (tick && run_cnt != RUN_LAST)  run_cnt <= run_cnt + 1'b1;
         if (reach) qualified <= 1'b1;
      end
   end

   assert_qual_on_k_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(qualified) |-> $past(ls_is_k) && $past(tick));
endmodule

// File: rtl/hcs_chirp_train.sv
module hcs_chirp_train #(
   parameter int CHIRP_TICKS = 100,
   parameter int PAIRS       = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic tick,
   output logic active,
   output logic level_j,
   output logic done
);
   localparam int NCHIRP = 2 * PAIRS;
   localparam int LW = $clog2(CHIRP_TICKS + 1);
   localparam int IW = $clog2(NCHIRP + 1);
   localparam logic [LW-1:0] LEN_LAST = LW'(CHIRP_TICKS - 1);
   localparam logic [IW-1:0] IDX_LAST = IW'(NCHIRP - 1);

   if (PAIRS < 1) begin : g_bad_pairs
      $error("hcs_chirp_train: PAIRS must be at least 1");
   end

   logic [LW-1:0] len_cnt;
   logic [IW-1:0] idx;
   logic          seg_end;

   assign seg_end = active && tick && (len_cnt == LEN_LAST);
   assign done    = seg_end && (idx == IDX_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         level_j <= 1'b0;
         len_cnt <= '0;
         idx     <= '0;
      end else if (start && !active) begin
         active  <= 1'b1;
         level_j <= 1'b0;
         len_cnt <= '0;
         idx     <= '0;
      end else if (seg_end) begin
         len_cnt <= '0;
         if (done) begin
            active  <= 1'b0;
            level_j <= 1'b0;
         end else begin
            idx     <= idx + 1'b1;
            level_j <= ~level_j;
         end
      end else if (active && tick) begin
         len_cnt <= len_cnt + 1'b1;
      end
   end

   assert_first_is_k_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> !level_j);
   assert_chirp_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active) && (level_j != $past(level_j)))
         |-> ($past(len_cnt) == LEN_LAST));
endmodule

// File: rtl/hcs_host_chirp_seq.sv
module hcs_host_chirp_seq
   import hcs_pkg::*;
#(
   parameter int TICKS_PER_US = 2,
   parameter int RESET_US     = 10000,
   parameter int GAP_US       = 20,
   parameter int CHIRP_US     = 50,
   parameter int PAIRS        = 3,
   parameter int KMIN_NS      = 2500,
   parameter int SYNC_STAGES  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       bus_reset_req,
   input  logic [1:0] linestate,
   output logic [1:0] opmode,
   output logic       se0_drive,
   output logic       txcmd_nopid,
   output logic       chirp_j,
   output logic       hs_mode,
   output logic       handshake_done
);
   localparam int RESET_TICKS = RESET_US * TICKS_PER_US;
   localparam int GAP_TICKS   = GAP_US * TICKS_PER_US;
   localparam int CHIRP_TICKS = CHIRP_US * TICKS_PER_US;
   localparam int KMIN_TICKS  = (KMIN_NS * TICKS_PER_US + 999) / 1000;
   localparam int TRAIN_US    = 2 * PAIRS * CHIRP_US;

   if (TICKS_PER_US < 1) begin : g_bad_tpu
      $error("hcs_host_chirp_seq: TICKS_PER_US must be at least 1");
   end
   if (CHIRP_US < 40 || CHIRP_US > 60) begin : g_bad_chirp
      $error("hcs_host_chirp_seq: CHIRP_US outside 40..60");
   end
   if (GAP_US < 1 || GAP_US > 90) begin : g_bad_gap
      $error("hcs_host_chirp_seq: GAP_US must leave margin under 100 us");
   end
   if (GAP_US + TRAIN_US >= RESET_US) begin : g_bad_reset
      $error("hcs_host_chirp_seq: train does not fit inside reset interval");
   end

   seq_state_t state, state_nx;
   logic rst_exp, gap_exp, q_qual, q_ended, tr_active, tr_level, tr_done;

   hcs_tick_timer #(.LIMIT(RESET_TICKS)) u_reset_timer (
      .clk(clk), .rst_n(rst_n), .run(state == ST_RESET), .tick(tick),
      .expire(rst_exp));

   hcs_tick_timer #(.LIMIT(GAP_TICKS)) u_gap_timer (
      .clk(clk), .rst_n(rst_n), .run(state == ST_GAP), .tick(tick),
      .expire(gap_exp));

   hcs_kchirp_qual #(.SYNC_STAGES(SYNC_STAGES), .MIN_TICKS(KMIN_TICKS)) u_qual (
      .clk(clk), .rst_n(rst_n), .arm(state == ST_RESET), .tick(tick),
      .linestate(linestate), .qualified(q_qual), .chirp_ended(q_ended));

   hcs_chirp_train #(.CHIRP_TICKS(CHIRP_TICKS), .PAIRS(PAIRS)) u_train (
      .clk(clk), .rst_n(rst_n), .start((state == ST_GAP) && gap_exp),
      .tick(tick), .active(tr_active), .level_j(tr_level), .done(tr_done));

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE, ST_HS, ST_FS: if (bus_reset_req) state_nx = ST_RESET;
         ST_RESET: begin
            if (q_ended)      state_nx = ST_GAP;
            else if (rst_exp) state_nx = ST_FS;
         end
         ST_GAP:   if (gap_exp) state_nx = ST_CHIRP;
         ST_CHIRP: if (tr_done) state_nx = ST_HS;
         default:  state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_nx;
   end

   always_comb begin
      unique case (state)
         ST_IDLE:                    opmode = OPM_NODRIVE;
         ST_RESET, ST_GAP, ST_CHIRP: opmode = OPM_RAW;
         default:                    opmode = OPM_NORMAL;
      endcase
   end

   assign se0_drive      = (state == ST_RESET) || (state == ST_GAP);
   assign txcmd_nopid    = tr_active;
   assign chirp_j        = tr_level;
   assign hs_mode        = (state == ST_HS);
   assign handshake_done = (state == ST_HS) || (state == ST_FS);

   assert_hs_after_train_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_mode) |-> $past(tr_done));
   assert_fs_after_se0_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FS && $past(state) != ST_FS) |-> $past(se0_drive) && !q_qual);
   assert_train_inside_chirp_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(txcmd_nopid) |-> $past(state) == ST_GAP);
endmodule

// File: tb/test_hcs_host_chirp_seq.sv
module test_hcs_host_chirp_seq;
   localparam int TPU    = 2;
   localparam int RST_US = 1500;
   localparam int CT     = 50 * TPU;
   localparam int NCH    = 6;
   localparam int RESET_TICKS = RST_US * TPU;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic req = 1'b0;
   logic [1:0] ls = 2'b00;
   logic [1:0] opmode;
   logic se0, txc, cj, hs, done;

   int checks = 0;
   int errors = 0;
   int div = 1;
   int tcnt = 0;
   int exp_lvl[$];
   int exp_len[$];

   always #4 clk = ~clk;

   hcs_host_chirp_seq #(.TICKS_PER_US(TPU), .RESET_US(RST_US)) i_hcs_host_chirp_seq (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_reset_req(req),
      .linestate(ls), .opmode(opmode), .se0_drive(se0), .txcmd_nopid(txc),
      .chirp_j(cj), .hs_mode(hs), .handshake_done(done));

   always @(negedge clk) begin
      if (div <= 1) tick <= 1'b1;
      else begin
         tick <= (tcnt == 0);
         tcnt <= (tcnt + 1) % div;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic push_train(input int d);
      for (int i = 0; i < NCH; i++) begin
         exp_lvl.push_back(i % 2);
         exp_len.push_back(CT * d);
      end
   endtask

   // monitor: measure each chirp segment and compare with scoreboard
   bit   m_prev = 1'b0;
   logic m_lvl = 1'b0;
   int   m_len = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (m_prev && (!txc || cj != m_lvl)) begin
            if (exp_lvl.size() == 0) begin
               check(1'b0, "R5 unexpected chirp", m_lvl, -1);
            end else begin
               int el, en;
               el = exp_lvl.pop_front();
               en = exp_len.pop_front();
               check(m_lvl == el, "R5 chirp level", m_lvl, el);
               check(m_len == en, "R6 chirp length", m_len, en);
            end
            m_len = 0;
         end
         if (txc) begin
            if (!m_prev) check(!se0, "R5 no se0 during train", se0, 0);
            m_lvl = cj;
            m_len++;
         end
         m_prev = txc;
      end
   end

   task automatic pulse_req();
      @(negedge clk); req = 1'b1;
      @(negedge clk); req = 1'b0;
   endtask

   // drive K for k_cycles, then SE0; stray K during gap; return cycles to train
   task automatic hs_run(input int k_cycles, input int d, input string tag);
      int lat;
      push_train(d);
      pulse_req();
      repeat (20) @(negedge clk);
      check(se0 && opmode == 2'b10, {tag, " R2 se0 during reset"}, {30'd0, opmode}, 2);
      ls = 2'b10;
      repeat (k_cycles) @(negedge clk);
      ls = 2'b00;
      lat = 0;
      while (!txc && lat < 5000) begin
         @(negedge clk);
         lat++;
         if (lat == 10) ls = 2'b10;   // stray K after acceptance (R9)
         if (lat == 20) ls = 2'b00;
      end
      check(txc == 1'b1, {tag, " R4 train started"}, txc, 1);
      check(lat <= 100 * TPU * d, {tag, " R4 latency"}, lat, 100 * TPU * d);
      begin
         int w = 0;
         while (!done && w < 20000) begin @(negedge clk); w++; end
      end
      @(negedge clk);
      check(hs == 1'b1 && done == 1'b1, {tag, " R7 hs status"}, hs, 1);
      check(opmode == 2'b00 && !se0, {tag, " R7 opmode normal"}, {30'd0, opmode}, 0);
      check(exp_lvl.size() == 0, {tag, " R5 all chirps seen (R9)"}, exp_lvl.size(), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(opmode == 2'b01, "R1 opmode idle", {30'd0, opmode}, 1);
      check(!se0 && !txc && !done && !hs, "R1 outputs idle", {28'd0, se0, txc, done, hs}, 0);

      // high speed at one tick per cycle, stray K in the gap
      hs_run(20, 1, "hs1");

      // full speed: K one tick short of the minimum; restart from done (R11)
      begin
         int se0_cnt = 0;
         int tx_seen = 0;
         int n = 0;
         @(negedge clk); req = 1'b1;
         @(negedge clk); req = 1'b0;
         check(se0 == 1'b1, "R11 restart from done", se0, 1);
         while (!done && n < 10000) begin
            if (se0) se0_cnt++;
            if (txc) tx_seen++;
            if (n == 20) ls = 2'b10;
            if (n == 24) ls = 2'b00;
            @(negedge clk);
            n++;
         end
         check(se0_cnt == RESET_TICKS, "R8 se0 length (R3 short K ignored)", se0_cnt, RESET_TICKS);
         check(tx_seen == 0, "R8 no train", tx_seen, 0);
         check(done && !hs && opmode == 2'b00, "R8 full-speed status", hs, 0);
      end

      // high speed at one tick every other cycle, K of exactly the minimum 5 ticks
      div = 2;
      hs_run(10, 2, "hs2 R3 R10");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule